// File: doc/BRIEF.md
# Two-Bank GPIO Interrupt Detector

This block watches sixteen general-purpose input lines, organised as two banks of eight, and raises one shared interrupt request when any enabled line has an event pending. Every line gets its own trigger setting from two bit-parallel registers in its bank. One register chooses between level and edge sensing. The other chooses the active sense: high level or rising edge, low level or falling edge.

Each bank has a mask register and a pending-status register. It also has a write-one-to-clear acknowledge register that releases latched edge events. Software programs the banks through a small APB-style register port. Every line is brought into the clock domain through a two-flop synchroniser before it is examined.

To reprogram a line, driver software first clears the bank's mask, then rewrites the trigger settings, then restores the mask. The block therefore masks at once when the mask is written. It also discards any latched edge whose trigger setting changes, so that switching modes cannot leave a stale request behind.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the trigger-kind, trigger-sense and mask registers of both banks read 0, the status registers read 0, and `irq_o` is low.
- R2: The registers are decoded at these byte offsets: bank 0 at 0x90 (kind), 0x94 (sense), 0x98 (acknowledge), 0x9C (mask) and 0xA0 (status); bank 1 at 0xAC, 0xB0, 0xB4, 0xB8 and 0xBC in the same order. Kind, sense and mask read back the last value written. The acknowledge offset reads 0, and any offset not listed reads 0.
- R3: A line with kind bit 0 is level sensed. With sense bit 1 it is pending while the input is high; with sense bit 0 it is pending while the input is low. It stops being pending once the input leaves that level.
- R4: A line with kind bit 1 is edge sensed. With sense bit 1 a rising edge sets a sticky pending bit; with sense bit 0 a falling edge sets it. The opposite edge sets nothing, and a set bit stays set after the input returns.
- R5: Writing 1 to a bit of a bank's acknowledge register clears that line's latched edge event, and writing 0 leaves it set. On a level-sensed line an acknowledge write does not change the status.
- R6: Status bit n of a bank reads (pending bit n AND mask bit n). A latched edge survives while its mask bit is 0 and reappears in status when the mask bit is set again.
- R7: A write of 0 to a bank's mask register clears that bank's status and removes its contribution to `irq_o` from the clock edge that completes the write.
- R8: A write that changes a line's kind bit or sense bit clears that line's pending state.
- R9: `irq_o` is high exactly when some status bit of bank 0 or bank 1 is 1.
- R10: An input change reaches the status register and `irq_o` on the third rising clock edge after it, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | LINES | Write data |
| prdata | output | LINES | Read data, valid during a selected read |
| gpio_in | input | 2*LINES | Raw input lines; bank 0 is the low half |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An input change needs three rising edges to reach status: one to the first synchroniser flop, one to the second, and one to the pending register. The bench drives inputs at a falling edge, waits four falling edges before reading status, and checks the latency itself by sampling `irq_o` after the second edge and again after the third. Register writes take effect at the edge that ends the access phase, so masking and mode-change effects are sampled at the next falling edge. Reads are combinational, and the scoreboard compares them one time unit after the falling edge that opens the access phase.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_BANKS = 2;
    localparam int SLOT_W    = 3;

    // Register slot inside one bank; the order fixes the offsets (4 bytes apart).
    typedef enum logic [SLOT_W-1:0] {
        SLOT_KIND  = 3'd0,
        SLOT_SENSE = 3'd1,
        SLOT_ACK   = 3'd2,
        SLOT_MASK  = 3'd3,
        SLOT_STAT  = 3'd4
    } slot_e;

    localparam int LAST_SLOT = 4;

    function automatic logic [7:0] bank_base(int idx);
        return (idx == 0) ? 8'h90 : 8'hAC;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = raw_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic         wr_i,
    input  slot_e        slot_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] kind_o,
    output logic [W-1:0] sense_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] stat_o
);

    typedef struct packed {
        logic [W-1:0] kind;
        logic [W-1:0] sense;
        logic [W-1:0] mask;
        logic [W-1:0] pend;
        logic [W-1:0] prev;
    } bank_t;

    bank_t st_d, st_q;

    logic [W-1:0] rise, fall, edge_hit, lvl_match, ack_bits, chg_bits;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_i;

        rise      = pin_i & ~st_q.prev;
        fall      = ~pin_i & st_q.prev;
        edge_hit  = st_q.kind & ((st_q.sense & rise) | (~st_q.sense & fall));
        lvl_match = ~(pin_i ^ st_q.sense);

        ack_bits = (wr_i && slot_i == SLOT_ACK) ? wdata_i : '0;
        chg_bits = '0;
        if (wr_i && slot_i == SLOT_KIND)  chg_bits = wdata_i ^ st_q.kind;
        if (wr_i && slot_i == SLOT_SENSE) chg_bits = wdata_i ^ st_q.sense;

        // Edge lines: sticky until acknowledged (new edge wins over ack).
        // Level lines: follow the input. Mode change: drop the line.
        st_d.pend = ~chg_bits & ((st_q.kind & ((st_q.pend & ~ack_bits) | edge_hit))
                               | (~st_q.kind & lvl_match));

        if (wr_i) begin
            case (slot_i)
                SLOT_KIND:  st_d.kind  = wdata_i;
                SLOT_SENSE: st_d.sense = wdata_i;
                SLOT_MASK:  st_d.mask  = wdata_i;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign kind_o  = st_q.kind;
    assign sense_o = st_q.sense;
    assign mask_o  = st_q.mask;
    assign stat_o  = st_q.pend & st_q.mask;

    // R7: a zero mask write silences the bank at the completing edge.
    assert_mask_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && slot_i == SLOT_MASK && wdata_i == '0) |=> (stat_o == '0));

    // R5: acknowledged edge lines with no fresh edge are clear afterwards.
    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && slot_i == SLOT_ACK) |=>
        ((st_q.pend & $past(wdata_i & st_q.kind & ~edge_hit)) == '0));

    // R4: a latched edge not acknowledged and not re-moded stays latched.
    assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.pend & st_q.kind & ~ack_bits & ~chg_bits) & ~st_q.pend) == '0));

    // R8: changing a line's trigger setting drops its pending state.
    assert_mode_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && slot_i == SLOT_KIND) |=> ((st_q.pend & $past(wdata_i ^ st_q.kind)) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      psel,
    input  logic                      penable,
    input  logic                      pwrite,
    input  logic [ADDR_W-1:0]         paddr,
    input  logic [LINES-1:0]          pwdata,
    output logic [LINES-1:0]          prdata,
    input  logic [NUM_BANKS*LINES-1:0] gpio_in,
    output logic                      irq_o
);

    localparam int ALL_LINES = NUM_BANKS * LINES;
    localparam int SPAN      = 4 * LAST_SLOT;

    logic [ALL_LINES-1:0]       pin_sync;
    logic [NUM_BANKS-1:0][LINES-1:0] bank_rd;
    logic [NUM_BANKS-1:0][LINES-1:0] bank_stat;
    logic [NUM_BANKS-1:0]            bank_any;

    gpio_sync #(.W(ALL_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (gpio_in),
        .sync_o (pin_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(bank_base(b));

        logic [ADDR_W-1:0] off;
        logic              hit;
        slot_e             slot;
        logic [LINES-1:0]  kind, sense, mask;

        assign off  = paddr - BASE;
        assign hit  = (paddr >= BASE) && (off <= ADDR_W'(SPAN)) && (off[1:0] == 2'b00);
        assign slot = slot_e'(off[SLOT_W+1:2]);

        gpio_irq_bank #(.W(LINES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_sync[b*LINES +: LINES]),
            .wr_i    (psel && penable && pwrite && hit),
            .slot_i  (slot),
            .wdata_i (pwdata),
            .kind_o  (kind),
            .sense_o (sense),
            .mask_o  (mask),
            .stat_o  (bank_stat[b])
        );

        always_comb begin
            bank_rd[b] = '0;
            if (hit) begin
                case (slot)
                    SLOT_KIND:  bank_rd[b] = kind;
                    SLOT_SENSE: bank_rd[b] = sense;
                    SLOT_MASK:  bank_rd[b] = mask;
                    SLOT_STAT:  bank_rd[b] = bank_stat[b];
                    default:    bank_rd[b] = '0;
                endcase
            end
        end

        assign bank_any[b] = |bank_stat[b];
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            for (int b = 0; b < NUM_BANKS; b++) prdata = prdata | bank_rd[b];
        end
    end

    assign irq_o = |bank_any;

    // R9: a raised request always has some bank reporting a pending line.
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (bank_stat != '0));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int LINES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [15:0] gpio_in = '0;
    logic        irq_o;

    always #4 clk = ~clk;

    gpio_irq_ctrl #(.LINES(LINES), .ADDR_W(8)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .gpio_in(gpio_in), .irq_o(irq_o)
    );

    typedef struct {
        bit         is_irq;
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    failures = 0;
    logic  probe = 1'b0;
    bit    done = 1'b0;

    // Monitor: compares each result with the oldest expectation.
    always @(negedge clk) begin
        #1;
        if ((psel && penable && !pwrite) || probe) begin
            item_t it;
            logic [7:0] act;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL scoreboard empty: actual=%h expected=none", prdata);
            end else begin
                it  = exp_q.pop_front();
                act = it.is_irq ? {7'd0, irq_o} : prdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic check_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    // Called at a falling edge; sampled 1 time unit later.
    task automatic check_irq(input logic e, input string tag);
        item_t it;
        it.is_irq = 1; it.addr = 8'hFF; it.exp = {7'd0, e}; it.tag = tag;
        exp_q.push_back(it);
        probe = 1;
        @(negedge clk); probe = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check_irq(0, "R1 irq after reset");
        check_rd(8'h90, 8'h00, "R1 bank0 kind");
        check_rd(8'h94, 8'h00, "R1 bank0 sense");
        check_rd(8'h9C, 8'h00, "R1 bank0 mask");
        check_rd(8'hA0, 8'h00, "R1 bank0 status");
        check_rd(8'hB8, 8'h00, "R1 bank1 mask");
        check_rd(8'hBC, 8'h00, "R1 bank1 status");

        // R2: map, readback, write-only and unmapped offsets
        apb_wr(8'h90, 8'h5A);
        apb_wr(8'hB0, 8'h3C);
        apb_wr(8'hB4, 8'hFF);
        check_rd(8'h90, 8'h5A, "R2 bank0 kind readback");
        check_rd(8'hB0, 8'h3C, "R2 bank1 sense readback");
        check_rd(8'hB4, 8'h00, "R2 ack reads zero");
        check_rd(8'h00, 8'h00, "R2 unmapped 0x00");
        check_rd(8'hA4, 8'h00, "R2 unmapped 0xA4");
        check_rd(8'h92, 8'h00, "R2 misaligned");
        apb_wr(8'h90, 8'h00);
        apb_wr(8'hB0, 8'h00);

        // R3: level sensing, active high on line 0, active low on line 1
        gpio_in[1] = 1'b1;
        apb_wr(8'h94, 8'h01);
        apb_wr(8'h9C, 8'h03);
        settle();
        check_rd(8'hA0, 8'h00, "R3 no level active");
        gpio_in[0] = 1'b1;
        settle();
        check_rd(8'hA0, 8'h01, "R3 high level pending");
        check_irq(1, "R9 irq from bank0 level");
        gpio_in[0] = 1'b0;
        settle();
        check_rd(8'hA0, 8'h00, "R3 high level released");
        gpio_in[1] = 1'b0;
        settle();
        check_rd(8'hA0, 8'h02, "R3 low level pending");
        apb_wr(8'h98, 8'h02);
        check_rd(8'hA0, 8'h02, "R5 ack ignored on level line");
        apb_wr(8'h9C, 8'h00);
        check_irq(0, "R7 mask zero drops irq at once");
        check_rd(8'hA0, 8'h00, "R7 masked status");

        // R10 / R4: rising edge on bank1 line 3 (gpio_in[11])
        apb_wr(8'hAC, 8'h08);
        apb_wr(8'hB0, 8'h08);
        apb_wr(8'hB8, 8'h08);
        settle();
        check_irq(0, "R10 idle before edge");
        gpio_in[11] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_irq(0, "R10 not yet after two edges");
        check_irq(1, "R10 due on third edge");
        gpio_in[11] = 1'b0;
        settle();
        check_rd(8'hBC, 8'h08, "R4 rising edge sticky");
        apb_wr(8'hB4, 8'h00);
        check_rd(8'hBC, 8'h08, "R5 ack zero keeps edge");
        apb_wr(8'hB4, 8'h08);
        check_rd(8'hBC, 8'h00, "R5 ack one clears edge");
        check_irq(0, "R5 irq gone after ack");

        // R4: falling edge on bank1 line 4 (gpio_in[12])
        apb_wr(8'hAC, 8'h18);
        apb_wr(8'hB8, 8'h18);
        gpio_in[12] = 1'b1;
        settle();
        check_rd(8'hBC, 8'h00, "R4 rising ignored on falling line");
        gpio_in[12] = 1'b0;
        settle();
        check_rd(8'hBC, 8'h10, "R4 falling edge latched");

        // R6: masked edge survives
        apb_wr(8'hB8, 8'h00);
        check_irq(0, "R7 bank1 mask zero");
        check_rd(8'hBC, 8'h00, "R6 masked status zero");
        apb_wr(8'hB8, 8'h18);
        check_rd(8'hBC, 8'h10, "R6 edge survives mask");

        // R8: sense change clears latched edge
        apb_wr(8'hB0, 8'h18);
        check_rd(8'hBC, 8'h00, "R8 sense change clears edge");
        check_irq(0, "R8 irq clear after mode change");

        // R9: combination across banks; bank0 line 7 rising
        apb_wr(8'h90, 8'h80);
        apb_wr(8'h94, 8'h80);
        apb_wr(8'h9C, 8'h80);
        gpio_in[7] = 1'b1;
        settle();
        check_rd(8'hBC, 8'h00, "R9 bank1 quiet");
        check_irq(1, "R9 irq from bank0 edge");
        apb_wr(8'h98, 8'h80);
        check_irq(0, "R9 irq low after bank0 ack");
        gpio_in[11] = 1'b1;
        settle();
        check_rd(8'hA0, 8'h00, "R9 bank0 quiet");
        check_irq(1, "R9 irq from bank1 edge");

        settle();
        wait (exp_q.size() == 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule